// File: doc/BRIEF.md
# Multi-Lane Time-Shared FIR Filter

This block is a programmable direct-form FIR filter with `TAPS` coefficients. It produces one output for each accepted input sample. The taps are spread over `LANES` parallel multiply-accumulate lanes. Each lane keeps its own slice of the sample history and its own slice of the coefficients, each read through its own local address. All lanes walk their slices together, one tap per clock. Because of this, one output costs `TAPS/LANES` MAC cycles instead of `TAPS`. Adding lanes therefore lowers the clock rate needed for a given sample rate.

A final adder stage sums the lane accumulators at full precision. It applies a fixed arithmetic right shift and presents the result with a one-cycle valid strobe. While a sample is being accumulated, `in_ready` is low and new samples wait. The coefficients can be rewritten at any time through a simple write port, so the same hardware can be retargeted to a different filter response.

Top module: `tsfir_top`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.
- R2: For the n-th accepted sample, `out_data` equals the low `OUT_W` bits of (sum over k of h[k]·x[n−k]) arithmetically shifted right by `OUT_SHIFT`. Here x is two's-complement signed, h is two's-complement signed, and tap 0 pairs with the newest sample.
- R3: A write with `coef_we` high at a rising edge sets h[`coef_addr`] to `coef_data`. The new value is used for every sample accepted afterwards.
- R4: A sample is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 for exactly `TAPS/LANES` cycles. A sample presented during that time is ignored and does not enter the history.
- R5: `out_valid` is a one-cycle pulse. It is high in the cycle that follows the (`TAPS/LANES`+1)-th rising edge after the accepting edge.
- R6: Accumulation never overflows. The largest-magnitude products (−2^(DATA_W−1) by −2^(COEF_W−1) on every tap) give the exact result.
- R7: Reset clears both the sample history and every coefficient to zero. Outputs computed before any coefficient write are therefore 0, and history positions not yet filled count as zero samples.
- R8: `TAPS` must be a multiple of `LANES`. A configuration that breaks this, or whose output slice does not fit the full-precision sum, stops elaboration.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Filter can take a sample |
| in_data | input | DATA_W | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | clog2(TAPS) | Tap index to write |
| coef_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OUT_W | Shifted filter output |

## Verification
The bench builds the filter with 8 taps on 4 lanes, 8-bit samples and coefficients, a shift of 2 and a 17-bit output. With these values, each sample takes two MAC cycles, and the whole 8-deep history turns over within a few samples. An impulse sweep can therefore read back every coefficient through the output. A long pseudo-random run, all-negative extremes and mid-stream coefficient rewrites all stay short. On every sample, the bench checks the busy window, the strobe position and the exact shifted sum from an arithmetic model. It also offers unwanted samples during busy windows, to show that they are refused.

// File: rtl/tsfir_pkg.sv
package tsfir_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;

   function automatic int clog2_min1(input int value);
      return (value <= 1) ? 1 : $clog2(value);
   endfunction

endpackage

// File: rtl/tsfir_seq.sv
module tsfir_seq
   import tsfir_pkg::*;
#(
   parameter int STEPS = 8,
   parameter int AW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   output logic          start,
   output logic          mac_en,
   output logic [AW-1:0] rd_addr,
   output logic          sum_en
);

   localparam logic [AW-1:0] LAST_ADDR = AW'(STEPS - 1);

   seq_state_t state_q;
   logic [AW-1:0] addr_q;
   logic          done_q;

   assign in_ready = (state_q == SEQ_IDLE);
   assign start    = in_valid && in_ready;
   assign mac_en   = (state_q == SEQ_RUN);
   assign rd_addr  = addr_q;
   assign sum_en   = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         addr_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_RUN;
                  addr_q  <= '0;
               end
            end
            SEQ_RUN: begin
               if (addr_q == LAST_ADDR) begin
                  state_q <= SEQ_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   // R4: an accepted sample always opens a busy window
   assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !in_ready);

   // R4: the local address never leaves the lane slice while running
   assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mac_en |-> (rd_addr <= LAST_ADDR));

   // R5: the sum strobe follows the final MAC step
   assert_sum_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mac_en && rd_addr == LAST_ADDR) |=> (sum_en && in_ready));

endmodule

// File: rtl/tsfir_lane.sv
module tsfir_lane #(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int STEPS  = 8,
   parameter int AW     = 3,
   parameter int ACC_W  = 35
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift_en,
   input  logic [DATA_W-1:0]        shift_in,
   output logic [DATA_W-1:0]        shift_out,
   input  logic                     cwr_en,
   input  logic [AW-1:0]            cwr_idx,
   input  logic [COEF_W-1:0]        cwr_val,
   input  logic                     clr,
   input  logic                     mac_en,
   input  logic [AW-1:0]            rd_addr,
   output logic signed [ACC_W-1:0]  acc
);

   localparam int PROD_W = DATA_W + COEF_W;

   logic [DATA_W-1:0] hist_q [STEPS];
   logic [COEF_W-1:0] coef_q [STEPS];
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  acc_q;

   assign shift_out = hist_q[STEPS-1];
   assign acc       = acc_q;
   assign prod      = $signed(hist_q[rd_addr]) * $signed(coef_q[rd_addr]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q[0] <= '0;
      end else if (shift_en) begin
         hist_q[0] <= shift_in;
      end
   end

   generate
      for (genvar k = 1; k < STEPS; k++) begin : g_hist
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist_q[k] <= '0;
            end else if (shift_en) begin
               hist_q[k] <= hist_q[k-1];
            end
         end
      end
      for (genvar k = 0; k < STEPS; k++) begin : g_coef
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               coef_q[k] <= '0;
            end else if (cwr_en && cwr_idx == AW'(k)) begin
               coef_q[k] <= cwr_val;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
      end else if (mac_en) begin
         acc_q <= acc_q + ACC_W'(prod);
      end
   end

   // R6: a cleared accumulator starts the sample from zero
   assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0));

endmodule

// File: rtl/tsfir_sum.sv
module tsfir_sum #(
   parameter int LANES     = 4,
   parameter int ACC_W     = 35,
   parameter int SUM_W     = 37,
   parameter int OUT_W     = 16,
   parameter int OUT_SHIFT = 15
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES*ACC_W-1:0] lane_acc,
   input  logic                   sum_en,
   output logic                   out_valid,
   output logic [OUT_W-1:0]       out_data
);

   logic signed [SUM_W-1:0] total;
   logic signed [SUM_W-1:0] shifted;

   generate
      if (LANES == 1) begin : g_single
         assign total = SUM_W'($signed(lane_acc[ACC_W-1:0]));
      end else begin : g_tree
         always_comb begin
            total = '0;
            for (int i = 0; i < LANES; i++) begin
               total = total + SUM_W'($signed(lane_acc[i*ACC_W +: ACC_W]));
            end
         end
      end
   endgenerate

   assign shifted = total >>> OUT_SHIFT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= sum_en;
         if (sum_en) begin
            out_data <= shifted[OUT_W-1:0];
         end
      end
   end

   // R5: the strobe lasts a single cycle
   assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R2: result register only moves when a strobe is issued
   assert_hold_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data) || $past(sum_en));

endmodule

// File: rtl/tsfir_top.sv
module tsfir_top
   import tsfir_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int COEF_W    = 16,
   parameter int TAPS      = 32,
   parameter int LANES     = 4,
   parameter int OUT_W     = 16,
   parameter int OUT_SHIFT = 15,
   localparam int CAW      = clog2_min1(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              coef_we,
   input  logic [CAW-1:0]    coef_addr,
   input  logic [COEF_W-1:0] coef_data,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data
);

   localparam int STEPS = TAPS / LANES;
   localparam int AW    = clog2_min1(STEPS);
   localparam int ACC_W = DATA_W + COEF_W + clog2_min1(STEPS);
   localparam int SUM_W = ACC_W + clog2_min1(LANES);

   // R8: configuration checks
   generate
      if (TAPS % LANES != 0) begin : g_bad_split_R8
         $error("tsfir_top: TAPS must be a multiple of LANES");
      end
      if (OUT_W + OUT_SHIFT > SUM_W) begin : g_bad_out_R8
         $error("tsfir_top: output slice exceeds full-precision sum");
      end
   endgenerate

   logic          start;
   logic          mac_en;
   logic          sum_en;
   logic [AW-1:0] rd_addr;
   logic [LANES*ACC_W-1:0] lane_acc;
   logic [DATA_W-1:0]      chain [LANES+1];
   logic [AW-1:0]          cwr_idx;
   logic [LANES-1:0]       cwr_sel;

   tsfir_seq #(
      .STEPS (STEPS),
      .AW    (AW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .start    (start),
      .mac_en   (mac_en),
      .rd_addr  (rd_addr),
      .sum_en   (sum_en)
   );

   always_comb begin
      int unsigned a;
      a       = int'(coef_addr);
      cwr_idx = AW'(a % STEPS);
      cwr_sel = '0;
      for (int i = 0; i < LANES; i++) begin
         if (coef_we && (a / STEPS) == i) cwr_sel[i] = 1'b1;
      end
   end

   assign chain[0] = in_data;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic signed [ACC_W-1:0] acc_i;
         tsfir_lane #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .STEPS  (STEPS),
            .AW     (AW),
            .ACC_W  (ACC_W)
         ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_en  (start),
            .shift_in  (chain[i]),
            .shift_out (chain[i+1]),
            .cwr_en    (cwr_sel[i]),
            .cwr_idx   (cwr_idx),
            .cwr_val   (coef_data),
            .clr       (start),
            .mac_en    (mac_en),
            .rd_addr   (rd_addr),
            .acc       (acc_i)
         );
         assign lane_acc[i*ACC_W +: ACC_W] = acc_i;
      end
   endgenerate

   tsfir_sum #(
      .LANES     (LANES),
      .ACC_W     (ACC_W),
      .SUM_W     (SUM_W),
      .OUT_W     (OUT_W),
      .OUT_SHIFT (OUT_SHIFT)
   ) u_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_acc  (lane_acc),
      .sum_en    (sum_en),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // R5: a strobe is preceded by a busy cycle two edges earlier
   assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> !$past(in_ready, 2));

   // R3: at most one lane takes a coefficient write
   assert_one_lane_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cwr_sel));

endmodule

// File: tb/tsfir_top_bench.sv
module tsfir_top_bench;

   localparam int DATA_W    = 8;
   localparam int COEF_W    = 8;
   localparam int TAPS      = 8;
   localparam int LANES     = 4;
   localparam int OUT_SHIFT = 2;
   localparam int OUT_W     = 17;
   localparam int STEPS     = TAPS / LANES;
   localparam int CAW       = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [DATA_W-1:0] in_data = '0;
   logic              coef_we = 1'b0;
   logic [CAW-1:0]    coef_addr = '0;
   logic [COEF_W-1:0] coef_data = '0;
   logic              out_valid;
   logic [OUT_W-1:0]  out_data;

   int errors = 0;
   int checks = 0;
   int hist  [TAPS];
   int hcoef [TAPS];
   int unsigned seed = 32'h1234_5678;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tsfir_top #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .LANES(LANES),
      .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)
   ) u_tsfir_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .coef_we(coef_we), .coef_addr(coef_addr),
      .coef_data(coef_data), .out_valid(out_valid), .out_data(out_data)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int next_rand();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'(seed >> 16);
   endfunction

   function automatic longint expected_out();
      longint s = 0;
      longint sh;
      for (int k = 0; k < TAPS; k++) s += longint'(hist[k]) * longint'(hcoef[k]);
      sh = s >>> OUT_SHIFT;
      return sh & ((longint'(1) << OUT_W) - 1);
   endfunction

   task automatic write_coef(input int idx, input int val);
      @(negedge clk);
      coef_we   = 1'b1;
      coef_addr = CAW'(idx);
      coef_data = COEF_W'(val);
      @(posedge clk);
      #1;
      coef_we = 1'b0;
      hcoef[idx] = val;
   endtask

   // send one sample; poke offers refused samples during the busy window (R4)
   task automatic send(input int x, input bit poke, input string req);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = DATA_W'(x);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      for (int j = 0; j <= STEPS; j++) begin
         @(negedge clk);
         if (j < STEPS) begin
            check("R4 in_ready low while busy", in_ready, 0);
            if (poke && j < STEPS - 1) begin
               in_valid = 1'b1;
               in_data  = DATA_W'(next_rand());
            end else begin
               in_valid = 1'b0;
            end
         end else begin
            in_valid = 1'b0;
         end
         check("R5 no early strobe", out_valid, 0);
         @(posedge clk);
      end
      @(negedge clk);
      check("R5 strobe position", out_valid, 1);
      check(req, longint'(out_data), expected_out());
      @(negedge clk);
      check("R5 strobe one cycle", out_valid, 0);
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < TAPS; k++) begin
         hist[k] = 0;
         hcoef[k] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 in_ready", in_ready, 1);
      check("R1 out_valid", out_valid, 0);
      check("R1 out_data", longint'(out_data), 0);

      // R7: zero coefficients after reset
      send(100, 1'b0, "R7 zero coefficients");
      send(-77, 1'b0, "R7 zero coefficients");

      // R3: program coefficients, impulse read-back through the output
      for (int k = 0; k < TAPS; k++) write_coef(k, (k % 2 == 0) ? (k + 1) * 9 : -(k + 1) * 7);
      for (int k = 0; k < TAPS; k++) send(0, 1'b0, "R7 flush");
      send(4, 1'b0, "R3 impulse tap");
      for (int k = 1; k < TAPS; k++) send(0, 1'b0, "R3 impulse tap");

      // R2 and R4: pseudo-random stream with refused samples
      for (int n = 0; n < 60; n++) begin
         send((next_rand() % 256) - 128, n % 3 == 0, "R2 random stream");
      end

      // R3: rewrite single coefficients mid-stream
      write_coef(5, 127);
      send(55, 1'b0, "R3 rewrite");
      write_coef(0, -128);
      for (int n = 0; n < 4; n++) send(-128 + n, 1'b1, "R3 rewrite");

      // R6: extreme products
      for (int k = 0; k < TAPS; k++) write_coef(k, -128);
      for (int n = 0; n < TAPS; n++) send(-128, 1'b0, "R6 max positive");
      for (int k = 0; k < TAPS; k++) write_coef(k, 127);
      for (int n = 0; n < TAPS; n++) send(-128, 1'b0, "R6 max negative");

      // R1/R7: reset clears history and coefficients
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      for (int k = 0; k < TAPS; k++) begin
         hist[k] = 0;
         hcoef[k] = 0;
      end
      @(negedge clk);
      check("R1 in_ready after reset", in_ready, 1);
      check("R1 out_valid after reset", out_valid, 0);
      write_coef(7, 50);
      send(3, 1'b0, "R7 history cleared");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule